// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block holds the power-control register of a small microcontroller and turns its contents into clock enables. Software writes the register to put the core into one of two low-power states. In the light state (idle), the processor clock is withheld while timers and the serial port keep their clock. In the deep state (power-down), both clocks are withheld. Idle ends when an interrupt becomes pending. Power-down ends only through reset.

The same register carries a baud-doubling flag for the serial port. The block forwards that flag as an effective doubling signal only when the serial port takes its rate from the default source. When an alternate baud source is selected, the flag is masked off. The flag itself keeps its stored value.

Register layout (8 bits): bit 7 is the baud-double flag, bit 1 requests power-down and bit 0 requests idle. Bits 6 to 2 are reserved and read as 0. The register is written through a single strobe with a data byte, and it can be read back at any time.

Top module: `pwr_ctl`

## Requirements
- R1: A synchronous active-low reset clears the register to 0x00 and returns the block to the running state. After reset, both clock enables follow `osc_en` and `baud_x2` is 0.
- R2: From the running state, a write with bit 0 = 1 and bit 1 = 0 enters idle. Bit 0 then reads 1, `cpu_clk_en` is 0 and `per_clk_en` equals `osc_en`.
- R3: In idle, `irq_pend` high at a clock edge returns the block to running at that edge. Hardware clears bit 0 and `cpu_clk_en` follows `osc_en` again.
- R4: From the running state, a write with bit 1 = 1 enters power-down. Bit 1 reads 1 and both clock enables are 0. If bit 0 is also 1 in that write, power-down wins and bit 0 reads 0.
- R5: In power-down, `irq_pend` has no effect: the register and both clock enables stay unchanged.
- R6: Power-down persists at every clock edge until `rst_n` is sampled low. Reset then returns the block to the running state with a register value of 0x00.
- R7: Writes made while in idle or power-down are ignored, the baud-double flag included.
- R8: Bit 7 stores the baud-double flag and reads back as written. `baud_x2` equals the flag when `baud_alt_sel` is 0, and is 0 when `baud_alt_sel` is 1.
- R9: Bits 6 to 2 read 0 whatever was written to them.
- R10: When `osc_en` is 0, both clock enables are 0 in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | Raw oscillator enable |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read-back value |
| irq_pend | input | 1 | Interrupt pending, wakes from idle |
| baud_alt_sel | input | 1 | Alternate baud source selected, masks doubling |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral (timer and serial) clock enable |
| baud_x2 | output | 1 | Effective baud-double signal |

## Verification
The hardest situation to reach from the ports is the mix of low-power state and stimulus that the block must refuse. Examples are an interrupt that arrives during power-down, a write that lands while the processor clock is withheld, and a combined idle-and-power-down write. The directed tasks first enter each state through a legal write. They then hold `irq_pend` or pulse `reg_wr` for several cycles and read the register and both enables before and after. This shows that the interrupt or write had no effect. Only a reset pulse is then used to leave power-down.

// File: rtl/pwr_pkg.sv
// Package: shared types and default field positions for the power controller.
// Assumes a single 8-bit control register with three live fields.
package pwr_pkg;
    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_mode_t;

    localparam int REG_W_DEF    = 8;
    localparam int DBL_POS_DEF  = 7;
    localparam int DOWN_POS_DEF = 1;
    localparam int IDLE_POS_DEF = 0;
endpackage

// File: rtl/pwr_reg_if.sv
// Register front end: decodes writes into state requests, holds the
// baud-double flag and assembles the read-back word.
// Assumes writes only take effect while the core is running.
module pwr_reg_if
    import pwr_pkg::*;
#(
    parameter int REG_W    = REG_W_DEF,
    parameter int DBL_POS  = DBL_POS_DEF,
    parameter int DOWN_POS = DOWN_POS_DEF,
    parameter int IDLE_POS = IDLE_POS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  pm_mode_t         mode,
    output logic             req_idle,
    output logic             req_down,
    output logic             dbl_flag,
    output logic [REG_W-1:0] rdata
);
    logic wr_go;
    logic dbl_q;
    logic unused_wdata;

    // accept a write only while the core is executing
    assign wr_go    = wr && (mode == PM_RUN);
    // power-down request wins over idle when both are set
    assign req_down = wr_go && wdata[DOWN_POS];
    assign req_idle = wr_go && wdata[IDLE_POS] && !wdata[DOWN_POS];
    assign unused_wdata = ^wdata;

    // store the baud-double flag on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbl_q <= 1'b0;
        else if (wr_go)
            dbl_q <= wdata[DBL_POS];
    end

    assign dbl_flag = dbl_q;

    // build the read-back word bit by bit
    for (genvar b = 0; b < REG_W; b++) begin : g_rd
        if (b == DBL_POS) begin : g_dbl
            assign rdata[b] = dbl_q;
        end else if (b == DOWN_POS) begin : g_down
            assign rdata[b] = (mode == PM_DOWN);
        end else if (b == IDLE_POS) begin : g_idle
            assign rdata[b] = (mode == PM_IDLE);
        end else begin : g_rsvd
            assign rdata[b] = 1'b0;
        end
    end

    // R7
    // flag holds its value across any cycle where a write is refused
    dbl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && mode != PM_RUN) |=> $stable(dbl_q));
endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode sequencer: running, idle and power-down, with their exit rules.
// Assumes wake is a level that stays high until serviced; reset is the
// only way out of power-down.
module pwr_mode_fsm
    import pwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_idle,
    input  logic     req_down,
    input  logic     wake,
    output pm_mode_t mode
);
    pm_mode_t mode_q, mode_d;

    // next-state selection per mode
    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            PM_RUN: begin
                if (req_down)
                    mode_d = PM_DOWN;
                else if (req_idle)
                    mode_d = PM_IDLE;
            end
            PM_IDLE: begin
                if (wake)
                    mode_d = PM_RUN;
            end
            PM_DOWN: mode_d = PM_DOWN;
            default: mode_d = PM_RUN;
        endcase
    end

    // mode register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= PM_RUN;
        else
            mode_q <= mode_d;
    end

    assign mode = mode_q;

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_IDLE && wake) |=> (mode_q == PM_RUN));

    // R5
    // R6
    down_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_DOWN) |=> (mode_q == PM_DOWN));

    // R4
    down_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_RUN && req_down) |=> (mode_q == PM_DOWN));
endmodule

// File: rtl/pwr_clk_gate.sv
// Clock-enable generator: maps the mode onto processor and peripheral
// enables, both qualified by the raw oscillator enable.
// Assumes the enables feed glitch-free gating cells downstream.
module pwr_clk_gate
    import pwr_pkg::*;
(
    input  logic     osc_en,
    input  pm_mode_t mode,
    output logic     cpu_en,
    output logic     per_en
);
    // processor runs only in the running mode
    assign cpu_en = osc_en && (mode == PM_RUN);
    // peripherals run in every mode except power-down
    assign per_en = osc_en && (mode != PM_DOWN);
endmodule

// File: rtl/pwr_baud_sel.sv
// Baud-double qualifier: passes the stored flag only when the serial
// port uses its default rate source.
module pwr_baud_sel (
    input  logic dbl_flag,
    input  logic alt_src,
    output logic dbl_eff
);
    // alternate rate source masks the doubling request
    assign dbl_eff = dbl_flag && !alt_src;
endmodule

// File: rtl/pwr_ctl.sv
// Top of the power controller: control register, mode sequencer, clock
// enables and baud-double qualification.
// Assumes clk is always running, independent of osc_en.
module pwr_ctl
    import pwr_pkg::*;
#(
    parameter int REG_W    = REG_W_DEF,
    parameter int DBL_POS  = DBL_POS_DEF,
    parameter int DOWN_POS = DOWN_POS_DEF,
    parameter int IDLE_POS = IDLE_POS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_pend,
    input  logic             baud_alt_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             baud_x2
);
    pm_mode_t mode;
    logic     req_idle;
    logic     req_down;
    logic     dbl_flag;

    pwr_reg_if #(
        .REG_W(REG_W), .DBL_POS(DBL_POS),
        .DOWN_POS(DOWN_POS), .IDLE_POS(IDLE_POS)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .mode(mode), .req_idle(req_idle), .req_down(req_down),
        .dbl_flag(dbl_flag), .rdata(reg_rdata)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_idle(req_idle),
        .req_down(req_down), .wake(irq_pend), .mode(mode)
    );

    pwr_clk_gate u_gate (
        .osc_en(osc_en), .mode(mode),
        .cpu_en(cpu_clk_en), .per_en(per_clk_en)
    );

    pwr_baud_sel u_baud (
        .dbl_flag(dbl_flag), .alt_src(baud_alt_sel), .dbl_eff(baud_x2)
    );

    // R10
    osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    // R2
    cpu_implies_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> per_clk_en);

    // R8
    alt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        baud_alt_sel |-> !baud_x2);

    // R4
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[DOWN_POS] && reg_rdata[IDLE_POS]));
endmodule

// File: tb/pwr_ctl_test.sv
// Directed bench for the power controller: one task per scenario.
module pwr_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_pend = 1'b0;
    logic       baud_alt_sel = 1'b0;
    logic       cpu_clk_en;
    logic       per_clk_en;
    logic       baud_x2;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwr_ctl uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pend(irq_pend),
        .baud_alt_sel(baud_alt_sel), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .baud_x2(baud_x2)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 cpu_en", {7'd0, cpu_clk_en}, 8'h01);
        chk("R1 per_en", {7'd0, per_clk_en}, 8'h01);
        chk("R1 baud_x2", {7'd0, baud_x2}, 8'h00);
    endtask

    task automatic t_baud();
        wr_reg(8'h80);
        chk("R8 rdata", reg_rdata, 8'h80);
        chk("R8 x2 default src", {7'd0, baud_x2}, 8'h01);
        baud_alt_sel = 1'b1;
        @(negedge clk);
        chk("R8 x2 alt src", {7'd0, baud_x2}, 8'h00);
        chk("R8 flag kept", reg_rdata, 8'h80);
        baud_alt_sel = 1'b0;
        @(negedge clk);
        chk("R8 x2 restored", {7'd0, baud_x2}, 8'h01);
        wr_reg(8'h7C);
        chk("R9 reserved bits", reg_rdata, 8'h00);
        wr_reg(8'hFC);
        chk("R9 reserved with flag", reg_rdata, 8'h80);
        wr_reg(8'h00);
    endtask

    task automatic t_idle();
        wr_reg(8'h81);
        chk("R2 rdata", reg_rdata, 8'h81);
        chk("R2 cpu_en", {7'd0, cpu_clk_en}, 8'h00);
        chk("R2 per_en", {7'd0, per_clk_en}, 8'h01);
        chk("R2 x2 kept", {7'd0, baud_x2}, 8'h01);
        wr_reg(8'h00);
        chk("R7 write in idle", reg_rdata, 8'h81);
        chk("R7 x2 in idle", {7'd0, baud_x2}, 8'h01);
        osc_en = 1'b0;
        @(negedge clk);
        chk("R10 per_en idle osc off", {7'd0, per_clk_en}, 8'h00);
        osc_en = 1'b1;
        irq_pend = 1'b1;
        @(negedge clk);
        irq_pend = 1'b0;
        chk("R3 rdata after wake", reg_rdata, 8'h80);
        chk("R3 cpu_en after wake", {7'd0, cpu_clk_en}, 8'h01);
        @(negedge clk);
        chk("R3 stays running", reg_rdata, 8'h80);
        wr_reg(8'h00);
    endtask

    task automatic t_osc_off_run();
        osc_en = 1'b0;
        @(negedge clk);
        chk("R10 cpu_en run osc off", {7'd0, cpu_clk_en}, 8'h00);
        chk("R10 per_en run osc off", {7'd0, per_clk_en}, 8'h00);
        osc_en = 1'b1;
        @(negedge clk);
        chk("R10 cpu_en osc back", {7'd0, cpu_clk_en}, 8'h01);
    endtask

    task automatic t_down_prec();
        wr_reg(8'h83);
        chk("R4 precedence rdata", reg_rdata, 8'h82);
        chk("R4 cpu_en", {7'd0, cpu_clk_en}, 8'h00);
        chk("R4 per_en", {7'd0, per_clk_en}, 8'h00);
        irq_pend = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 irq in down rdata", reg_rdata, 8'h82);
        chk("R5 irq in down cpu_en", {7'd0, cpu_clk_en}, 8'h00);
        chk("R5 irq in down per_en", {7'd0, per_clk_en}, 8'h00);
        irq_pend = 1'b0;
        wr_reg(8'h01);
        chk("R7 write in down", reg_rdata, 8'h82);
        pulse_reset();
        chk("R6 reset exits down", reg_rdata, 8'h00);
        chk("R6 cpu_en after reset", {7'd0, cpu_clk_en}, 8'h01);
        chk("R6 per_en after reset", {7'd0, per_clk_en}, 8'h01);
    endtask

    task automatic t_down_plain();
        wr_reg(8'h02);
        chk("R4 plain down rdata", reg_rdata, 8'h02);
        repeat (5) @(negedge clk);
        chk("R6 down persists", reg_rdata, 8'h02);
        pulse_reset();
        chk("R6 second reset", reg_rdata, 8'h00);
    endtask

    initial begin : watchdog
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_baud();
        t_idle();
        t_osc_off_run();
        t_down_prec();
        t_down_plain();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule